// File: doc/BRIEF.md
# Nibble-Extended Shift and Rotate Unit

This block shifts or rotates a 16-bit operand by one to four places. A 4-bit shift buffer (SB) sits beside it. SB catches the bits that fall off the operand and supplies bits to later rotates. This lets software chain a wide value through the unit one word at a time. The unit provides logical left, logical right and arithmetic right shifts, and rotates in both directions. The carry flag is never involved.

Each operation is presented for one cycle with `opValid`. The registered result, negative and zero flags, and a one-cycle `resValid` strobe appear after the next clock edge. A downstream add or OR stage can qualify on that strobe. An operation whose kind contradicts its direction raises `opError` instead. A separate load port writes SB, and `sbValue` always shows SB. An interrupt wrapper can use these two ports to save and restore SB across a context switch.

Top module: `nibble_shift_unit`

## Requirements
- R1: After reset, `result` is 0, `flagN` and `flagZ` are 0, `resValid` and `opError` are 0, and `sbValue` is 0.
- R2: `amtCode[2]` selects the direction: 0 is left and 1 is right. The distance is `amtCode[1:0]`+1, so codes 0..3 shift left by 1..4 and codes 4..7 shift right by 1..4. `opKind` encodes the operation as 0 = logical left, 1 = logical right, 2 = arithmetic right and 3 = rotate.
- R3: Logical left forms the 20-bit value {SB, operand} and shifts it left, filling with zeros. Bits 15:0 become the result and bits 19:16 become the new SB.
- R4: Logical right forms {operand, SB} and shifts it right, filling with zeros. Bits 19:4 become the result and bits 3:0 become the new SB.
- R5: Arithmetic right works as R4, except that the vacated upper bits are filled with operand bit 15.
- R6: Rotate left forms the 24-bit value {SB, operand, SB} and shifts it left. Bits 23:20 become the new SB and bits 19:4 become the result.
- R7: Rotate right forms {SB, operand, SB} and shifts it right. Bits 3:0 become the new SB and bits 19:4 become the result.
- R8: With every valid result, `flagN` equals result bit 15 and `flagZ` is 1 exactly when the result is 0.
- R9: An accepted operation sets `resValid` high for exactly the cycle after the edge that samples it. While `opValid` is low, `resValid` and `opError` are low, and `result`, the flags and SB keep their values.
- R10: Logical left with `amtCode[2]`=1, or either right shift with `amtCode[2]`=0, is illegal. An illegal operation raises `opError` for one cycle, keeps `resValid` low, and leaves the result, the flags and SB unchanged.
- R11: `sbLoad` writes `sbLoadData` into SB, which is visible on `sbValue` after the edge. If an operation arrives in the same cycle, the operation uses the old SB and the load wins the SB write.
- R12: The SB left by one operation is the SB used by the next one. For example, two rotates carry bits from one word into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation request for this cycle |
| opKind | input | 2 | Operation select (R2 encoding) |
| amtCode | input | 3 | Direction and distance code |
| operand | input | 16 | Word to shift or rotate |
| sbLoad | input | 1 | Write SB from `sbLoadData` |
| sbLoadData | input | 4 | Value for SB restore |
| result | output | 16 | Registered result |
| flagN | output | 1 | Negative flag of the result |
| flagZ | output | 1 | Zero flag of the result |
| resValid | output | 1 | One-cycle strobe: new result present |
| opError | output | 1 | One-cycle strobe: illegal operation |
| sbValue | output | 4 | Current shift buffer |

## Verification
SB is the only state that outlives an operation. A corrupted SB stays hidden through plain shifts that push it out, but it shows on `sbValue` one cycle later. It also shows in the top or bottom nibble of the next rotate's result. The bench therefore compares `sbValue` after every operation, and long random runs of mixed rotates expose a stale buffer within one or two operations. A decode error shows at once, because it either raises `opError` wrongly or leaves the expected SB update missing in the same cycle.

// File: rtl/nsu_pkg.sv
`timescale 1ns/1ps
package nsu_pkg;

  typedef enum logic [1:0] {
    OP_SHL = 2'd0,
    OP_SHR = 2'd1,
    OP_SAR = 2'd2,
    OP_ROT = 2'd3
  } nsu_op_e;

  // strobes from decode to datapath
  typedef struct packed {
    logic fire;      // legal operation this cycle
    logic bad;       // illegal kind/direction pair
    logic goLeft;    // direction
    logic wrap;      // rotate through SB on both ends
    logic signFill;  // arithmetic fill on right shift
  } nsu_strobe_t;

endpackage

// File: rtl/nsu_ctrl.sv
`timescale 1ns/1ps
module nsu_ctrl
  import nsu_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              opValid,
  input  logic [1:0]        opKind,
  input  logic [CODE_W-1:0] amtCode,
  output nsu_strobe_t       strobe,
  output logic [CODE_W-1:0] amt
);

  localparam int LOW_W = CODE_W - 1;

  nsu_op_e kind;
  logic    dirRight;
  logic    legal;

  assign kind     = nsu_op_e'(opKind);
  assign dirRight = amtCode[CODE_W-1];

  // distance is the low field plus one for both directions
  assign amt = {1'b0, amtCode[LOW_W-1:0]} + CODE_W'(1);

  always_comb begin
    legal           = 1'b0;
    strobe.wrap     = 1'b0;
    strobe.signFill = 1'b0;
    unique case (kind)
      OP_SHL: legal = !dirRight;
      OP_SHR: legal = dirRight;
      OP_SAR: begin
        legal           = dirRight;
        strobe.signFill = 1'b1;
      end
      OP_ROT: begin
        legal       = 1'b1;
        strobe.wrap = 1'b1;
      end
      default: legal = 1'b0;
    endcase
    strobe.goLeft = !dirRight;
    strobe.fire   = opValid && legal;
    strobe.bad    = opValid && !legal;
  end

endmodule

// File: rtl/nsu_datapath.sv
`timescale 1ns/1ps
module nsu_datapath
  import nsu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SB_W   = 4,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  nsu_strobe_t       strobe,
  input  logic [CODE_W-1:0] amt,
  input  logic [DATA_W-1:0] operand,
  input  logic              sbLoad,
  input  logic [SB_W-1:0]   sbLoadData,
  output logic [DATA_W-1:0] result,
  output logic              flagN,
  output logic              flagZ,
  output logic              resValid,
  output logic              opError,
  output logic [SB_W-1:0]   sbValue
);

  localparam int WIDE_W = DATA_W + SB_W;
  localparam int ROT_W  = DATA_W + 2 * SB_W;

  logic [SB_W-1:0]          sbQ;
  logic [DATA_W-1:0]        resultQ;
  logic                     nQ, zQ, validQ, errQ;

  logic [WIDE_W-1:0]        wideLeft;
  logic [WIDE_W-1:0]        wideRight;
  logic signed [WIDE_W-1:0] rightSrcS;
  logic [ROT_W-1:0]         rotSrc;
  logic [ROT_W-1:0]         rotLeft;
  logic [ROT_W-1:0]         rotRight;
  logic [DATA_W-1:0]        nextRes;
  logic [SB_W-1:0]          nextSb;

  // shift sources: SB extends the operand on the side bits leave from
  assign wideLeft  = {sbQ, operand} << amt;
  assign rightSrcS = {operand, sbQ};
  assign wideRight = strobe.signFill ? WIDE_W'(rightSrcS >>> amt)
                                     : ({operand, sbQ} >> amt);
  assign rotSrc    = {sbQ, operand, sbQ};
  assign rotLeft   = rotSrc << amt;
  assign rotRight  = rotSrc >> amt;

  always_comb begin
    if (strobe.wrap) begin
      if (strobe.goLeft) begin
        nextRes = rotLeft[ROT_W-SB_W-1:SB_W];
        nextSb  = rotLeft[ROT_W-1:ROT_W-SB_W];
      end else begin
        nextRes = rotRight[ROT_W-SB_W-1:SB_W];
        nextSb  = rotRight[SB_W-1:0];
      end
    end else if (strobe.goLeft) begin
      nextRes = wideLeft[DATA_W-1:0];
      nextSb  = wideLeft[WIDE_W-1:DATA_W];
    end else begin
      nextRes = wideRight[WIDE_W-1:SB_W];
      nextSb  = wideRight[SB_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      nQ      <= 1'b0;
      zQ      <= 1'b0;
      validQ  <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      validQ <= strobe.fire;
      errQ   <= strobe.bad;
      if (strobe.fire) begin
        resultQ <= nextRes;
        nQ      <= nextRes[DATA_W-1];
        zQ      <= (nextRes == '0);
      end
    end
  end

  // save/restore load has priority over the operation's SB update
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sbQ <= '0;
    end else if (sbLoad) begin
      sbQ <= sbLoadData;
    end else if (strobe.fire) begin
      sbQ <= nextSb;
    end
  end

  assign result   = resultQ;
  assign flagN    = nQ;
  assign flagZ    = zQ;
  assign resValid = validQ;
  assign opError  = errQ;
  assign sbValue  = sbQ;

endmodule

// File: rtl/nibble_shift_unit.sv
`timescale 1ns/1ps
module nibble_shift_unit
  import nsu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SB_W   = 4,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opKind,
  input  logic [CODE_W-1:0] amtCode,
  input  logic [DATA_W-1:0] operand,
  input  logic              sbLoad,
  input  logic [SB_W-1:0]   sbLoadData,
  output logic [DATA_W-1:0] result,
  output logic              flagN,
  output logic              flagZ,
  output logic              resValid,
  output logic              opError,
  output logic [SB_W-1:0]   sbValue
);

  nsu_strobe_t       strobe;
  logic [CODE_W-1:0] amt;

  nsu_ctrl #(.CODE_W(CODE_W)) ctrl_i (
    .opValid (opValid),
    .opKind  (opKind),
    .amtCode (amtCode),
    .strobe  (strobe),
    .amt     (amt)
  );

  nsu_datapath #(.DATA_W(DATA_W), .SB_W(SB_W), .CODE_W(CODE_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .amt        (amt),
    .operand    (operand),
    .sbLoad     (sbLoad),
    .sbLoadData (sbLoadData),
    .result     (result),
    .flagN      (flagN),
    .flagZ      (flagZ),
    .resValid   (resValid),
    .opError    (opError),
    .sbValue    (sbValue)
  );

endmodule

// File: rtl/nsu_checker.sv
`timescale 1ns/1ps
module nsu_checker #(
  parameter int DATA_W = 16,
  parameter int SB_W   = 4,
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [1:0]        opKind,
  input logic [CODE_W-1:0] amtCode,
  input logic              sbLoad,
  input logic [SB_W-1:0]   sbLoadData,
  input logic [DATA_W-1:0] result,
  input logic              flagN,
  input logic              flagZ,
  input logic              resValid,
  input logic              opError,
  input logic [SB_W-1:0]   sbValue
);

  logic illegalReq;
  assign illegalReq = ((opKind == 2'd0) && amtCode[CODE_W-1]) ||
                      (((opKind == 2'd1) || (opKind == 2'd2)) && !amtCode[CODE_W-1]);

  a_r8_neg_flag: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (flagN == result[DATA_W-1]));

  a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (flagZ == (result == '0)));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!resValid && !opError));

  a_r9_legal_valid: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !illegalReq) |=> (resValid && !opError));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid && !sbLoad) |=> ($stable(result) && $stable(sbValue)));

  a_r10_flags_error: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && illegalReq) |=> (opError && !resValid));

  a_r10_sb_kept: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && illegalReq && !sbLoad) |=> $stable(sbValue));

  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    sbLoad |=> (sbValue == $past(sbLoadData)));

endmodule

bind nibble_shift_unit nsu_checker #(.DATA_W(DATA_W), .SB_W(SB_W), .CODE_W(CODE_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .opValid    (opValid),
  .opKind     (opKind),
  .amtCode    (amtCode),
  .sbLoad     (sbLoad),
  .sbLoadData (sbLoadData),
  .result     (result),
  .flagN      (flagN),
  .flagZ      (flagZ),
  .resValid   (resValid),
  .opError    (opError),
  .sbValue    (sbValue)
);

// File: tb/nibble_shift_unit_tb_top.sv
`timescale 1ns/1ps
module nibble_shift_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid;
  logic [1:0]  opKind;
  logic [2:0]  amtCode;
  logic [15:0] operand;
  logic        sbLoad;
  logic [3:0]  sbLoadData;
  logic [15:0] result;
  logic        flagN, flagZ, resValid, opError;
  logic [3:0]  sbValue;

  int checks = 0;
  int errors = 0;

  logic [3:0]  sbModel  = '0;
  logic [15:0] resModel = '0;
  logic        nModel   = 1'b0;
  logic        zModel   = 1'b0;

  always #2.5 clk = ~clk;

  nibble_shift_unit dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .amtCode(amtCode), .operand(operand), .sbLoad(sbLoad),
    .sbLoadData(sbLoadData), .result(result), .flagN(flagN),
    .flagZ(flagZ), .resValid(resValid), .opError(opError),
    .sbValue(sbValue)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // R2..R7 expected behaviour, returns {newSb, result}
  function automatic logic [19:0] model(input logic [1:0] kind, input logic [2:0] code,
                                        input logic [15:0] d, input logic [3:0] sb);
    int          n;
    logic [19:0] w;
    logic [23:0] r;
    n = int'(code[1:0]) + 1;
    if (kind == 2'd3) begin
      r = {sb, d, sb};
      if (!code[2]) begin r = r << n; return {r[23:20], r[19:4]}; end
      else          begin r = r >> n; return {r[3:0],   r[19:4]}; end
    end else if (kind == 2'd0) begin
      w = {sb, d} << n;
      return {w[19:16], w[15:0]};
    end else begin
      w = {d, sb};
      for (int i = 0; i < n; i++) w = {(kind == 2'd2) ? w[19] : 1'b0, w[19:1]};
      return {w[3:0], w[19:4]};
    end
  endfunction

  function automatic string kindTag(input logic [1:0] kind, input logic [2:0] code);
    case (kind)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return code[2] ? "R7" : "R6";
    endcase
  endfunction

  task automatic step(input logic v, input logic [1:0] kind, input logic [2:0] code,
                      input logic [15:0] d, input logic ld, input logic [3:0] ldData,
                      input string extraTag);
    logic        legal;
    logic [19:0] m;
    logic        expValid, expErr;
    string       tag;
    @(negedge clk);
    opValid = v; opKind = kind; amtCode = code; operand = d;
    sbLoad = ld; sbLoadData = ldData;
    legal = (kind == 2'd3) || ((kind == 2'd0) ? !code[2] : code[2]);
    m = model(kind, code, d, sbModel);
    expValid = v && legal;
    expErr   = v && !legal;
    if (expValid) begin
      resModel = m[15:0];
      nModel   = m[15];
      zModel   = (m[15:0] == 16'h0);
    end
    if (ld) sbModel = ldData;
    else if (expValid) sbModel = m[19:16];
    tag = expValid ? kindTag(kind, code) : (expErr ? "R10" : "R9");
    if (extraTag != "") tag = {tag, "/", extraTag};
    @(posedge clk); #1;
    check(resValid == expValid, {tag, " R9 valid"}, resValid, expValid);
    check(opError == expErr, {tag, " R10 error"}, opError, expErr);
    check(result == resModel, {tag, " R2 result"}, result, resModel);
    check(flagN == nModel, {tag, " R8 N"}, flagN, nModel);
    check(flagZ == zModel, {tag, " R8 Z"}, flagZ, zModel);
    check(sbValue == sbModel, {tag, ld ? " R11 sb" : " sb"}, sbValue, sbModel);
    opValid = 1'b0; sbLoad = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rstN = 1'b0; opValid = 1'b0; opKind = '0; amtCode = '0; operand = '0;
    sbLoad = 1'b0; sbLoadData = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    // R1 reset state
    check(result == 16'h0, "R1 result", result, 0);
    check({flagN, flagZ} == 2'b00, "R1 flags", {flagN, flagZ}, 0);
    check({resValid, opError} == 2'b00, "R1 strobes", {resValid, opError}, 0);
    check(sbValue == 4'h0, "R1 sb", sbValue, 0);

    // directed corners
    step(1, 2'd0, 3'd3, 16'h8001, 1'b1, 4'hA, "R11");   // load wins, op uses old SB 0
    step(1, 2'd0, 3'd3, 16'h8001, 1'b0, 4'h0, "R2");    // left 4 with SB=A
    step(1, 2'd2, 3'd7, 16'h8000, 1'b0, 4'h0, "R5");    // sign fill
    step(1, 2'd1, 3'd4, 16'h8000, 1'b0, 4'h0, "R4");
    step(1, 2'd0, 3'd3, 16'hF000, 1'b0, 4'h0, "R8");    // zero result
    step(1, 2'd0, 3'd5, 16'h1234, 1'b0, 4'h0, "R10");   // illegal left/right
    step(1, 2'd1, 3'd1, 16'h1234, 1'b0, 4'h0, "R10");
    step(0, 2'd0, 3'd0, 16'hFFFF, 1'b0, 4'h0, "R9");    // idle holds
    step(1, 2'd3, 3'd3, 16'h1234, 1'b1, 4'h0, "R12");
    step(1, 2'd3, 3'd3, 16'h0000, 1'b0, 4'h0, "R12");   // SB chains into rotate
    step(1, 2'd3, 3'd7, 16'h00F1, 1'b0, 4'h0, "R7");
    step(1, 2'd3, 3'd4, 16'h0000, 1'b0, 4'h0, "R12");
    step(1, 2'd3, 3'd0, 16'h8000, 1'b0, 4'h0, "R6");

    for (int i = 0; i < 600; i++) begin
      step(($urandom % 8) != 0, 2'($urandom % 4), 3'($urandom % 8), 16'($urandom),
           ($urandom % 7) == 0, 4'($urandom), "R12");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule